// File: doc/BRIEF.md
# In-Order Completion Buffer

This block tracks every in-flight instruction from the moment it is dispatched until it retires, so that results become architectural strictly in program order even when execution finishes out of order. It is a 16-entry circular buffer. Dispatch claims up to four consecutive slots per cycle. Each slot records a rename tag, a destination register number and a bit saying whether a destination exists. Execution units later mark a slot finished by its index, optionally flagging a fault.

Each cycle the four oldest slots are inspected. The longest run of finished, fault-free slots starting at the head retires. Retired slots that carry a destination are queued for register writeback, and that queue drains at most two results per cycle. A faulting slot that reaches the head is never retired. It raises an exception request carrying its index, and the whole buffer is emptied on the next edge. A branch mispredict names the branch's slot, and every younger slot is discarded in one cycle.

Top module: `inorder_cbuf`

## Requirements
- R1: After reset the buffer is empty: `retireCnt` is 0, `excValid` is 0, no `wbValid` lane is set, `dispBase` is 0 and `full` is 0 while nothing is offered.
- R2: Lane k of an accepted dispatch receives slot index (`dispBase` + k) mod 16. `dispBase` advances by the accepted count on the next edge and wraps from 15 to 0.
- R3: `full` is 1 exactly when `dispCnt` exceeds the number of free slots. While it is 1 nothing is allocated and `dispBase` holds.
- R4: `retireCnt` equals the length of the contiguous run of finished, non-faulting slots starting at the head, capped at 4. A finished slot behind an unfinished one does not retire.
- R5: Retired slots whose destination bit is set appear on the `wbValid`/`wbTag`/`wbDest` lanes, at most two per cycle and in program order, starting the cycle after retirement, with lane 0 holding the oldest. Leftovers follow in later cycles. Slots without a destination produce no writeback.
- R6: When the head slot is finished with its fault bit set, `excValid` is 1, `excIdx` equals the head index and `retireCnt` is 0. On the next edge all slots are discarded and `dispBase` equals that index.
- R7: While `flushValid` is 1, nothing retires and nothing is allocated. On the next edge every slot younger than `flushIdx` is discarded and `dispBase` becomes `flushIdx` + 1 mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dispCnt | input | 3 | Number of instructions offered this cycle (0 to 4), packed from lane 0 |
| dispTag | input | 24 | Rename tag per lane, lane k at bits [6k+5:6k] |
| dispDest | input | 20 | Destination register per lane, lane k at bits [5k+4:5k] |
| dispHasDest | input | 4 | Per-lane flag: instruction writes a register |
| dispBase | output | 4 | Slot index that lane 0 would receive |
| full | output | 1 | Offered count exceeds free slots; dispatch stalls |
| finValid | input | 2 | Per finish port: a slot finished execution |
| finIdx | input | 8 | Slot index per finish port, port p at bits [4p+3:4p] |
| finExc | input | 2 | Per finish port: the finishing instruction faulted |
| flushValid | input | 1 | Branch mispredict: discard slots younger than `flushIdx` |
| flushIdx | input | 4 | Slot index of the mispredicted branch |
| retireCnt | output | 3 | Number of slots retiring at the coming edge |
| excValid | output | 1 | Faulting instruction at head; full flush follows |
| excIdx | output | 4 | Slot index of the faulting instruction |
| wbValid | output | 2 | Writeback lanes carrying a result, lane 0 oldest |
| wbTag | output | 12 | Rename tag per writeback lane |
| wbDest | output | 10 | Destination register per writeback lane |

## Verification
The bench targets out-of-order finishing. A design that retired any finished slot rather than the contiguous run from the head would report a nonzero count while the head is still pending. It also fills the buffer to exactly 16 and probes both sides of the free-slot boundary, where an off-by-one compare would either overwrite live slots or stall one slot early. Mispredict and fault flushes are exercised with younger slots already finished: a design that kept them alive would retire too many, and one that reset the tail to zero instead of the branch or head index would hand out the wrong slot numbers. A wrapping sweep of mixed dispatch widths, and a mask of destination bits, catch pointer wrap errors and writeback compaction that leaks slots without a destination or reorders results.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic alloc;     // write the offered lanes into free slots
    logic retire;    // head slots leave the buffer this edge
    logic flushAll;  // fault at head: clear every status bit
  } cbStrobe_t;

endpackage

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
  import cbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int WB_W   = 2,
  parameter int WBQ_D  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(DISP_W+1)-1:0]  dispCnt,
  input  logic                         flushValid,
  input  logic [$clog2(DEPTH)-1:0]     flushIdx,
  input  logic [RET_W-1:0]             peekDone,
  input  logic [RET_W-1:0]             peekExc,
  input  logic [RET_W-1:0]             peekHasDest,
  output cbStrobe_t                    strobe,
  output logic [$clog2(DEPTH)-1:0]     headPtr,
  output logic [$clog2(DEPTH)-1:0]     tailPtr,
  output logic [$clog2(RET_W+1)-1:0]   retCnt,
  output logic                         excNow,
  output logic                         full,
  output logic [$clog2(WBQ_D)-1:0]     wbqHead,
  output logic [$clog2(WBQ_D)-1:0]     wbqTail,
  output logic [WB_W-1:0]              wbLaneValid
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int RC_W  = $clog2(RET_W + 1);
  localparam int WQ_W  = $clog2(WBQ_D);
  localparam int WQC_W = $clog2(WBQ_D + 1);

  logic [IDX_W-1:0] headQ, tailQ, brOff;
  logic [CNT_W-1:0] countQ, freeN;
  logic [WQ_W-1:0]  wbqHeadQ, wbqTailQ;
  logic [WQC_W-1:0] wbqCountQ, wbPop, wbFree, destN;
  logic [RC_W-1:0]  retN;
  logic             runOk, allocOk;

  // Occupancy and dispatch admission
  always_comb begin
    freeN   = CNT_W'(DEPTH) - countQ;
    full    = int'(dispCnt) > int'(freeN);
    excNow  = (countQ != '0) && peekDone[0] && peekExc[0];
    allocOk = (dispCnt != '0) && !full && !flushValid && !excNow;
    brOff   = flushIdx - headQ;
  end

  // Writeback staging space: drained lanes free up this same edge
  always_comb begin
    wbPop  = (int'(wbqCountQ) > WB_W) ? WQC_W'(WB_W) : wbqCountQ;
    wbFree = WQC_W'(WBQ_D) - wbqCountQ + wbPop;
  end

  // In-order retire scan over the oldest RET_W slots
  always_comb begin
    retN  = '0;
    destN = '0;
    runOk = 1'b1;
    for (int k = 0; k < RET_W; k++) begin
      if (runOk && (k < int'(countQ)) && peekDone[k] && !peekExc[k] &&
          !flushValid && !excNow &&
          (int'(destN) + int'(peekHasDest[k]) <= int'(wbFree))) begin
        retN  = retN + RC_W'(1);
        destN = destN + WQC_W'(peekHasDest[k]);
      end else begin
        runOk = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ     <= '0;
      tailQ     <= '0;
      countQ    <= '0;
      wbqHeadQ  <= '0;
      wbqTailQ  <= '0;
      wbqCountQ <= '0;
    end else begin
      if (excNow) begin
        countQ <= '0;
        tailQ  <= headQ;
      end else if (flushValid) begin
        countQ <= CNT_W'(brOff) + CNT_W'(1);
        tailQ  <= flushIdx + IDX_W'(1);
      end else begin
        headQ  <= headQ + IDX_W'(retN);
        tailQ  <= allocOk ? tailQ + IDX_W'(dispCnt) : tailQ;
        countQ <= countQ - CNT_W'(retN) + (allocOk ? CNT_W'(dispCnt) : CNT_W'(0));
      end
      wbqHeadQ  <= wbqHeadQ + WQ_W'(wbPop);
      wbqTailQ  <= wbqTailQ + WQ_W'(destN);
      wbqCountQ <= wbqCountQ - wbPop + destN;
    end
  end

  always_comb begin
    strobe.alloc    = allocOk;
    strobe.retire   = (retN != '0);
    strobe.flushAll = excNow;
    for (int j = 0; j < WB_W; j++) begin
      wbLaneValid[j] = j < int'(wbqCountQ);
    end
  end

  assign headPtr = headQ;
  assign tailPtr = tailQ;
  assign retCnt  = retN;
  assign wbqHead = wbqHeadQ;
  assign wbqTail = wbqTailQ;

endmodule

// File: rtl/cbuf_data.sv
module cbuf_data
  import cbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int WB_W   = 2,
  parameter int FIN_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DEST_W = 5,
  parameter int WBQ_D  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cbStrobe_t                        strobe,
  input  logic [$clog2(DEPTH)-1:0]         headPtr,
  input  logic [$clog2(DEPTH)-1:0]         tailPtr,
  input  logic [$clog2(DISP_W+1)-1:0]      dispCnt,
  input  logic [DISP_W*TAG_W-1:0]          dispTag,
  input  logic [DISP_W*DEST_W-1:0]         dispDest,
  input  logic [DISP_W-1:0]                dispHasDest,
  input  logic [FIN_W-1:0]                 finValid,
  input  logic [FIN_W*$clog2(DEPTH)-1:0]   finIdx,
  input  logic [FIN_W-1:0]                 finExc,
  input  logic [$clog2(RET_W+1)-1:0]       retCnt,
  input  logic [$clog2(WBQ_D)-1:0]         wbqHead,
  input  logic [$clog2(WBQ_D)-1:0]         wbqTail,
  output logic [RET_W-1:0]                 peekDone,
  output logic [RET_W-1:0]                 peekExc,
  output logic [RET_W-1:0]                 peekHasDest,
  output logic [WB_W*TAG_W-1:0]            wbTag,
  output logic [WB_W*DEST_W-1:0]           wbDest
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int WQ_W  = $clog2(WBQ_D);

  logic [DEPTH-1:0]  doneQ, excQ, entHas;
  logic [TAG_W-1:0]  entTag  [DEPTH];
  logic [DEST_W-1:0] entDest [DEPTH];
  logic [TAG_W-1:0]  qTag    [WBQ_D];
  logic [DEST_W-1:0] qDest   [WBQ_D];

  logic [IDX_W-1:0]  allocIdx [DISP_W];
  logic [IDX_W-1:0]  peekIdx  [RET_W];
  logic [WQ_W-1:0]   pushSlot [RET_W];
  logic [RET_W-1:0]  pushEn;
  logic [WQ_W-1:0]   slotOff;

  always_comb begin
    for (int k = 0; k < DISP_W; k++) begin
      allocIdx[k] = tailPtr + IDX_W'(k);
    end
    for (int k = 0; k < RET_W; k++) begin
      peekIdx[k]     = headPtr + IDX_W'(k);
      peekDone[k]    = doneQ[peekIdx[k]];
      peekExc[k]     = excQ[peekIdx[k]];
      peekHasDest[k] = entHas[peekIdx[k]];
    end
  end

  // Compact retiring slots that write a register into the staging queue
  always_comb begin
    slotOff = '0;
    for (int k = 0; k < RET_W; k++) begin
      pushEn[k]   = strobe.retire && (k < int'(retCnt)) && peekHasDest[k];
      pushSlot[k] = wbqTail + slotOff;
      if (pushEn[k]) slotOff = slotOff + WQ_W'(1);
    end
  end

  // Status bits: finish marks, cleared on allocation or full flush
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= '0;
      excQ  <= '0;
    end else if (strobe.flushAll) begin
      doneQ <= '0;
      excQ  <= '0;
    end else begin
      for (int f = 0; f < FIN_W; f++) begin
        if (finValid[f]) begin
          doneQ[finIdx[f*IDX_W +: IDX_W]] <= 1'b1;
          excQ[finIdx[f*IDX_W +: IDX_W]]  <= finExc[f];
        end
      end
      for (int k = 0; k < DISP_W; k++) begin
        if (strobe.alloc && (k < int'(dispCnt))) begin
          doneQ[allocIdx[k]] <= 1'b0;
          excQ[allocIdx[k]]  <= 1'b0;
        end
      end
    end
  end

  // Slot payload
  always_ff @(posedge clk) begin
    for (int k = 0; k < DISP_W; k++) begin
      if (strobe.alloc && (k < int'(dispCnt))) begin
        entTag[allocIdx[k]]  <= dispTag[k*TAG_W +: TAG_W];
        entDest[allocIdx[k]] <= dispDest[k*DEST_W +: DEST_W];
        entHas[allocIdx[k]]  <= dispHasDest[k];
      end
    end
  end

  // Writeback staging storage
  always_ff @(posedge clk) begin
    for (int k = 0; k < RET_W; k++) begin
      if (pushEn[k]) begin
        qTag[pushSlot[k]]  <= entTag[peekIdx[k]];
        qDest[pushSlot[k]] <= entDest[peekIdx[k]];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < WB_W; j++) begin
      wbTag[j*TAG_W +: TAG_W]    = qTag[wbqHead + WQ_W'(j)];
      wbDest[j*DEST_W +: DEST_W] = qDest[wbqHead + WQ_W'(j)];
    end
  end

endmodule

// File: rtl/inorder_cbuf.sv
module inorder_cbuf
  import cbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int WB_W   = 2,
  parameter int FIN_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DEST_W = 5,
  parameter int WBQ_D  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [$clog2(DISP_W+1)-1:0]      dispCnt,
  input  logic [DISP_W*TAG_W-1:0]          dispTag,
  input  logic [DISP_W*DEST_W-1:0]         dispDest,
  input  logic [DISP_W-1:0]                dispHasDest,
  output logic [$clog2(DEPTH)-1:0]         dispBase,
  output logic                             full,
  input  logic [FIN_W-1:0]                 finValid,
  input  logic [FIN_W*$clog2(DEPTH)-1:0]   finIdx,
  input  logic [FIN_W-1:0]                 finExc,
  input  logic                             flushValid,
  input  logic [$clog2(DEPTH)-1:0]         flushIdx,
  output logic [$clog2(RET_W+1)-1:0]       retireCnt,
  output logic                             excValid,
  output logic [$clog2(DEPTH)-1:0]         excIdx,
  output logic [WB_W-1:0]                  wbValid,
  output logic [WB_W*TAG_W-1:0]            wbTag,
  output logic [WB_W*DEST_W-1:0]           wbDest
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int WQ_W  = $clog2(WBQ_D);
  localparam int RC_W  = $clog2(RET_W + 1);

  cbStrobe_t        strobe;
  logic [IDX_W-1:0] headPtr, tailPtr;
  logic [RC_W-1:0]  retCnt;
  logic [WQ_W-1:0]  wbqHead, wbqTail;
  logic [RET_W-1:0] peekDone, peekExc, peekHasDest;

  cbuf_ctrl #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .WB_W(WB_W), .WBQ_D(WBQ_D)
  ) ctrl (
    .clk(clk), .rstN(rstN), .dispCnt(dispCnt),
    .flushValid(flushValid), .flushIdx(flushIdx),
    .peekDone(peekDone), .peekExc(peekExc), .peekHasDest(peekHasDest),
    .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr),
    .retCnt(retCnt), .excNow(excValid), .full(full),
    .wbqHead(wbqHead), .wbqTail(wbqTail), .wbLaneValid(wbValid)
  );

  cbuf_data #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .WB_W(WB_W), .FIN_W(FIN_W),
    .TAG_W(TAG_W), .DEST_W(DEST_W), .WBQ_D(WBQ_D)
  ) data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr),
    .dispCnt(dispCnt), .dispTag(dispTag), .dispDest(dispDest), .dispHasDest(dispHasDest),
    .finValid(finValid), .finIdx(finIdx), .finExc(finExc),
    .retCnt(retCnt), .wbqHead(wbqHead), .wbqTail(wbqTail),
    .peekDone(peekDone), .peekExc(peekExc), .peekHasDest(peekHasDest),
    .wbTag(wbTag), .wbDest(wbDest)
  );

  assign dispBase  = tailPtr;
  assign excIdx    = headPtr;
  assign retireCnt = retCnt;

endmodule

// File: rtl/inorder_cbuf_chk.sv
module inorder_cbuf_chk #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int WB_W   = 2
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [$clog2(DISP_W+1)-1:0]    dispCnt,
  input logic [$clog2(DEPTH)-1:0]       dispBase,
  input logic                           full,
  input logic                           flushValid,
  input logic [$clog2(DEPTH)-1:0]       flushIdx,
  input logic [$clog2(RET_W+1)-1:0]     retireCnt,
  input logic                           excValid,
  input logic [$clog2(DEPTH)-1:0]       excIdx,
  input logic [WB_W-1:0]                wbValid
);

  localparam int IDX_W = $clog2(DEPTH);

  AST_ALLOC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (dispCnt != '0 && !full && !flushValid && !excValid)
      |=> dispBase == $past(dispBase) + IDX_W'($past(dispCnt))); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !flushValid && !excValid) |=> $stable(dispBase)); // R3

  AST_RETIRE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    int'(retireCnt) <= RET_W); // R4

  AST_EXC_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> retireCnt == '0); // R6

  AST_EXC_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (dispBase == $past(excIdx)) && !excValid); // R6

  AST_MISP_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> retireCnt == '0); // R7

  AST_MISP_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && !excValid) |=> dispBase == $past(flushIdx) + IDX_W'(1)); // R7

  generate
    for (genvar j = 1; j < WB_W; j++) begin : g_wbOrder
      AST_WB_PACKED: assert property (@(posedge clk) disable iff (!rstN)
        wbValid[j] |-> wbValid[j-1]); // R5
    end
  endgenerate

endmodule

bind inorder_cbuf inorder_cbuf_chk #(
  .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .WB_W(WB_W)
) chk (
  .clk(clk), .rstN(rstN), .dispCnt(dispCnt), .dispBase(dispBase), .full(full),
  .flushValid(flushValid), .flushIdx(flushIdx), .retireCnt(retireCnt),
  .excValid(excValid), .excIdx(excIdx), .wbValid(wbValid)
);

// File: tb/inorder_cbuf_test.sv
`timescale 1ns/1ps
module inorder_cbuf_test;

  localparam int DEPTH  = 16;
  localparam int DISP_W = 4;
  localparam int RET_W  = 4;
  localparam int WB_W   = 2;
  localparam int FIN_W  = 4;
  localparam int TAG_W  = 6;
  localparam int DEST_W = 5;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int DC_W   = $clog2(DISP_W + 1);
  localparam int RC_W   = $clog2(RET_W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DC_W-1:0]          dispCnt = '0;
  logic [DISP_W*TAG_W-1:0]  dispTag = '0;
  logic [DISP_W*DEST_W-1:0] dispDest = '0;
  logic [DISP_W-1:0]        dispHasDest = '0;
  logic [IDX_W-1:0]         dispBase;
  logic                     full;
  logic [FIN_W-1:0]         finValid = '0;
  logic [FIN_W*IDX_W-1:0]   finIdx = '0;
  logic [FIN_W-1:0]         finExc = '0;
  logic                     flushValid = 1'b0;
  logic [IDX_W-1:0]         flushIdx = '0;
  logic [RC_W-1:0]          retireCnt;
  logic                     excValid;
  logic [IDX_W-1:0]         excIdx;
  logic [WB_W-1:0]          wbValid;
  logic [WB_W*TAG_W-1:0]    wbTag;
  logic [WB_W*DEST_W-1:0]   wbDest;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  inorder_cbuf #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .WB_W(WB_W), .FIN_W(FIN_W),
    .TAG_W(TAG_W), .DEST_W(DEST_W)
  ) uut (
    .clk(clk), .rstN(rstN), .dispCnt(dispCnt), .dispTag(dispTag), .dispDest(dispDest),
    .dispHasDest(dispHasDest), .dispBase(dispBase), .full(full),
    .finValid(finValid), .finIdx(finIdx), .finExc(finExc),
    .flushValid(flushValid), .flushIdx(flushIdx), .retireCnt(retireCnt),
    .excValid(excValid), .excIdx(excIdx), .wbValid(wbValid), .wbTag(wbTag), .wbDest(wbDest)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle();
    dispCnt = '0;
    dispHasDest = '0;
    finValid = '0;
    finExc = '0;
    flushValid = 1'b0;
  endtask

  task automatic lane(input int k, input int tag, input int dest, input bit hd);
    dispTag[k*TAG_W +: TAG_W]    = TAG_W'(tag);
    dispDest[k*DEST_W +: DEST_W] = DEST_W'(dest);
    dispHasDest[k]               = hd;
  endtask

  task automatic fin(input int p, input int idx, input bit ex);
    finValid[p]                = 1'b1;
    finIdx[p*IDX_W +: IDX_W]   = IDX_W'(idx);
    finExc[p]                  = ex;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    // ---------------- reset state (R1)
    doReset();
    settle();
    check("R1", "retireCnt", int'(retireCnt), 0);
    check("R1", "excValid", int'(excValid), 0);
    check("R1", "wbValid", int'(wbValid), 0);
    check("R1", "dispBase", int'(dispBase), 0);
    check("R1", "full", int'(full), 0);

    // ---------------- fill all 16 slots, tag = idx+10, dest = idx+1 (R2)
    for (int b = 0; b < 4; b++) begin
      dispCnt = DC_W'(4);
      for (int k = 0; k < 4; k++) lane(k, b*4 + k + 10, b*4 + k + 1, 1'b1);
      settle();
      check("R2", "dispBase during fill", int'(dispBase), b*4);
      check("R3", "full with room", int'(full), 0);
      tick();
    end
    idle();
    dispCnt = DC_W'(1);
    settle();
    check("R3", "full when no free slot", int'(full), 1);
    dispCnt = '0;
    settle();
    check("R3", "full with nothing offered", int'(full), 0);

    // ---------------- out-of-order finish (R4)
    fin(0, 1, 1'b0); fin(1, 2, 1'b0);
    tick(); idle(); settle();
    check("R4", "retire blocked by unfinished head", int'(retireCnt), 0);
    fin(0, 0, 1'b0);
    tick(); idle(); settle();
    check("R4", "contiguous run of 3", int'(retireCnt), 3);
    tick(); settle();
    // 3 results staged, two per cycle (R5)
    check("R5", "wbValid first", int'(wbValid), 3);
    check("R5", "wbTag lane0", int'(wbTag[0 +: TAG_W]), 10);
    check("R5", "wbTag lane1", int'(wbTag[TAG_W +: TAG_W]), 11);
    check("R5", "wbDest lane1", int'(wbDest[DEST_W +: DEST_W]), 2);
    dispCnt = DC_W'(3); settle();
    check("R3", "full with 3 offered 3 free", int'(full), 0);
    dispCnt = DC_W'(4); settle();
    check("R3", "full with 4 offered 3 free", int'(full), 1);
    dispCnt = '0;
    tick(); settle();
    check("R5", "wbValid leftover", int'(wbValid), 1);
    check("R5", "wbTag leftover", int'(wbTag[0 +: TAG_W]), 12);
    check("R5", "wbDest leftover", int'(wbDest[0 +: DEST_W]), 3);
    tick(); settle();
    check("R5", "wbValid drained", int'(wbValid), 0);

    // ---------------- retire cap of 4 (R4)
    fin(0, 10, 1'b0); fin(1, 9, 1'b0); fin(2, 8, 1'b0); fin(3, 7, 1'b0);
    tick(); idle();
    fin(0, 6, 1'b0); fin(1, 5, 1'b0); fin(2, 4, 1'b0); fin(3, 3, 1'b0);
    tick(); idle(); settle();
    check("R4", "retire capped first", int'(retireCnt), 4);
    tick(); settle();
    check("R4", "retire capped second", int'(retireCnt), 4);
    tick(); settle();
    check("R4", "retire stops at unfinished", int'(retireCnt), 0);

    // ---------------- mispredict flush (R7)
    doReset();
    dispCnt = DC_W'(4);
    for (int k = 0; k < 4; k++) lane(k, k, k, 1'b0);
    tick();
    for (int k = 0; k < 4; k++) lane(k, k + 4, k, 1'b0);
    tick(); idle();
    fin(0, 3, 1'b0); fin(1, 4, 1'b0); fin(2, 5, 1'b0); fin(3, 6, 1'b0);
    tick(); idle();
    fin(0, 7, 1'b0);
    tick(); idle();
    flushValid = 1'b1; flushIdx = IDX_W'(2);
    dispCnt = DC_W'(1);
    lane(0, 33, 1, 1'b0);
    settle();
    check("R7", "retire during flush", int'(retireCnt), 0);
    tick(); idle(); settle();
    check("R7", "dispBase after flush", int'(dispBase), 3);
    fin(0, 0, 1'b0); fin(1, 1, 1'b0); fin(2, 2, 1'b0);
    tick(); idle(); settle();
    check("R7", "only older slots retire", int'(retireCnt), 3);
    tick(); settle();
    check("R7", "younger slots discarded", int'(retireCnt), 0);

    // ---------------- fault at head (R6)
    doReset();
    dispCnt = DC_W'(4);
    for (int k = 0; k < 4; k++) lane(k, 40 + k, 5 + k, 1'b1);
    tick(); idle();
    fin(0, 0, 1'b0); fin(1, 1, 1'b1); fin(2, 2, 1'b0);
    tick(); idle(); settle();
    check("R6", "older slot retires first", int'(retireCnt), 1);
    check("R6", "no exception before fault reaches head", int'(excValid), 0);
    tick(); settle();
    check("R6", "excValid", int'(excValid), 1);
    check("R6", "excIdx", int'(excIdx), 1);
    check("R6", "no retire of faulting slot", int'(retireCnt), 0);
    check("R5", "older result written", int'(wbValid), 1);
    check("R5", "older result tag", int'(wbTag[0 +: TAG_W]), 40);
    tick(); settle();
    check("R6", "exception cleared", int'(excValid), 0);
    check("R6", "dispBase at faulting index", int'(dispBase), 1);
    check("R6", "faulting result not written", int'(wbValid), 0);
    fin(0, 3, 1'b0);
    tick(); idle(); settle();
    check("R6", "flushed slots do not retire", int'(retireCnt), 0);

    // ---------------- destination mask compaction (R5)
    doReset();
    dispCnt = DC_W'(4);
    for (int k = 0; k < 4; k++) lane(k, 50 + k, 9 + k, (k % 2) == 0);
    tick(); idle();
    for (int k = 0; k < 4; k++) fin(k, k, 1'b0);
    tick(); idle(); settle();
    check("R4", "all four retire", int'(retireCnt), 4);
    tick(); settle();
    check("R5", "two of four write", int'(wbValid), 3);
    check("R5", "compact lane0 tag", int'(wbTag[0 +: TAG_W]), 50);
    check("R5", "compact lane1 tag", int'(wbTag[TAG_W +: TAG_W]), 52);
    check("R5", "compact lane1 dest", int'(wbDest[DEST_W +: DEST_W]), 11);
    tick(); settle();
    check("R5", "no further writes", int'(wbValid), 0);

    // ---------------- wrapping sweep of dispatch widths (R2, R4)
    doReset();
    begin
      int expTail;
      expTail = 0;
      for (int i = 0; i < 24; i++) begin
        int n;
        n = (i % 4) + 1;
        dispCnt = DC_W'(n);
        for (int k = 0; k < 4; k++) lane(k, i, k, 1'b0);
        settle();
        check("R2", "sweep dispBase", int'(dispBase), expTail);
        tick(); idle();
        for (int k = 0; k < n; k++) fin(k, (expTail + k) % DEPTH, 1'b0);
        tick(); idle(); settle();
        check("R4", "sweep retireCnt", int'(retireCnt), n);
        tick();
        expTail = (expTail + n) % DEPTH;
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule